// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the control and register core of a small accumulator computer. A machine word is 16 bits: bit 15 is the indirect flag, bits 14..12 hold a 3-bit operation code and bits 11..0 hold a 12-bit address. A step counter produces one-hot timing slots T0 to T6. The slots drive the fetch, the decode, the optional indirect address lookup, and the execute phase of the memory-reference operations. The block holds the program counter, address, instruction, data and accumulator registers. It also holds the indirect flag and the interrupt-cycle flag. It owns the address, write data and write strobe of an external memory word array.

The memory returns read data within the same cycle for the address the block presents, and it commits a write at the clock edge. Interrupt requests arrive as three level inputs: an enable, an input-ready flag and an output-ready flag. A pending request is taken at the next instruction boundary. It diverts one three-slot cycle that saves the return address in word 0 and resumes at word 1. All architectural registers are brought out as ports for observation.

Top module: `acc_seq_core`

## Requirements
- R1: After the active-low reset is released, the step is 0 (T0), the interrupt flag is 0 and PC, AR, IR, DR, AC and the indirect flag are all zero.
- R2: With the interrupt flag clear: T0 copies PC into AR; T1 loads IR from memory at AR and increments PC; T2 copies IR[11:0] into AR and IR[15] into the indirect flag. The operation code is IR[14:12].
- R3: In T3, when the operation code is not 111 and the indirect flag is 1, AR is reloaded from the low 12 bits of memory at AR. Otherwise T3 changes no register.
- R4: Codes 000 (AND), 001 (ADD, result modulo 2^16) and 010 (LOAD) read memory at AR into DR in T4. In T5 they set AC to AC&DR, AC+DR or DR respectively, and the instruction ends.
- R5: Code 011 (STORE) writes AC to memory at AR in T4 and ends. Code 100 (JUMP) copies AR into PC in T4 and ends.
- R6: Code 101 (CALL) writes the zero-extended PC to memory at AR and increments AR in T4. It copies AR into PC in T5 and ends.
- R7: Code 110 (increment, skip if zero) reads memory at AR into DR in T4 and increments DR in T5. In T6 it writes DR back to memory at AR, increments PC when DR is zero, and ends.
- R8: Code 111 changes no register and writes no memory. Its instruction ends at T4.
- R9: The interrupt flag is set at a clock edge when the step is not T0, T1 or T2, the enable input is 1 and at least one of the two ready inputs is 1. Otherwise it does not become set.
- R10: When the interrupt flag is 1, the three slots instead do the following. T0 clears AR. T1 writes the old PC to memory word 0 and clears PC. T2 sets PC to 1, clears the flag and ends the cycle.
- R11: The memory write strobe is high only in interrupt T1, in T4 of STORE or CALL, and in T6 of code 110. Each instruction makes at most one write.
- R12: When an instruction ends, the step returns to T0 at the next edge. If the interrupt flag is then 1, that slot starts an interrupt cycle and not a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ien_i | input | 1 | Interrupt enable |
| fgi_i | input | 1 | Input-ready request flag |
| fgo_i | input | 1 | Output-ready request flag |
| mem_rdata_i | input | 16 | Memory read data for mem_addr_o |
| mem_addr_o | output | 12 | Memory address (always AR) |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| pc_o | output | 12 | Program counter |
| ar_o | output | 12 | Address register |
| ir_o | output | 16 | Instruction register |
| dr_o | output | 16 | Data register |
| ac_o | output | 16 | Accumulator |
| ind_o | output | 1 | Latched indirect flag |
| irq_cyc_o | output | 1 | Interrupt-cycle flag |
| step_o | output | 3 | Current timing slot number (0 = T0) |

## Verification
Two events can land in the same cycle. In T6 of the increment-and-skip operation, the step counter clears and PC may advance. In that same cycle, a request may set the interrupt flag. The bench raises the output-ready flag exactly in that T6, on an operand of FFFF, so the skip is taken. The result is judged correct when the next slot is an interrupt T0 and word 0 then receives the already-skipped PC. A second case holds a request asserted through T0..T2 and confirms that the flag stays clear until T3.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int OP_W   = 3;
  localparam int N_OPS  = 1 << OP_W;
  localparam int T_NUM  = 7;
  localparam int STEP_W = $clog2(T_NUM);

  typedef enum logic [OP_W-1:0] {
    OP_AND     = 3'd0,
    OP_ADD     = 3'd1,
    OP_LOAD    = 3'd2,
    OP_STORE   = 3'd3,
    OP_JUMP    = 3'd4,
    OP_CALL    = 3'd5,
    OP_INCSKIP = 3'd6,
    OP_OTHER   = 3'd7
  } op_e;
endpackage

// File: rtl/acc_seq_timer.sv
module acc_seq_timer #(
  parameter int NT = 7,
  parameter int SW = $clog2(NT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [SW-1:0] step_o,
  output logic [NT-1:0] t_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               step_o <= '0;
    else if (clr_i || step_o == SW'(NT - 1))   step_o <= '0;
    else                                       step_o <= step_o + SW'(1);
  end

  for (genvar k = 0; k < NT; k++) begin : g_slot
    assign t_o[k] = (step_o == SW'(k));
  end
endmodule

// File: rtl/acc_seq_decode.sv
module acc_seq_decode #(
  parameter int OW = 3,
  parameter int NL = 1 << OW
) (
  input  logic [OW-1:0] code_i,
  output logic [NL-1:0] line_o
);
  for (genvar k = 0; k < NL; k++) begin : g_line
    assign line_o[k] = (code_i == OW'(k));
  end
endmodule

// File: rtl/acc_seq_irq.sv
module acc_seq_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic early_i,
  input  logic clr_i,
  input  logic ien_i,
  input  logic fgi_i,
  input  logic fgo_i,
  output logic r_o
);
  logic set_w;
  assign set_w = !early_i && ien_i && (fgi_i || fgo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     r_o <= 1'b0;
    else if (set_w)  r_o <= 1'b1;
    else if (clr_i)  r_o <= 1'b0;
  end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int WORD_W = ADDR_W + OP_W + 1,
  localparam int SW     = STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ien_i,
  input  logic              fgi_i,
  input  logic              fgo_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [WORD_W-1:0] ir_o,
  output logic [WORD_W-1:0] dr_o,
  output logic [WORD_W-1:0] ac_o,
  output logic              ind_o,
  output logic              irq_cyc_o,
  output logic [SW-1:0]     step_o
);
  logic [ADDR_W-1:0] pc_q, ar_q;
  logic [WORD_W-1:0] ir_q, dr_q, ac_q;
  logic              ind_q, r_q, done_w;
  logic [T_NUM-1:0]  t_w;
  logic [N_OPS-1:0]  d_w;

  acc_seq_timer #(.NT(T_NUM), .SW(SW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(done_w), .step_o(step_o), .t_o(t_w)
  );

  acc_seq_decode #(.OW(OP_W), .NL(N_OPS)) u_dec (
    .code_i(ir_q[WORD_W-2 -: OP_W]), .line_o(d_w)
  );

  acc_seq_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .early_i(t_w[0] | t_w[1] | t_w[2]),
    .clr_i(r_q & t_w[2]),
    .ien_i(ien_i), .fgi_i(fgi_i), .fgo_i(fgo_i), .r_o(r_q)
  );

  // slot qualifiers
  logic fe0, fe1, fe2, ir0, ir1, ir2, ind3, rd4;
  logic and5, add5, lda5, sta4, bun4, bsa4, bsa5, isz5, isz6, oth4;
  always_comb begin
    fe0  = !r_q & t_w[0];
    fe1  = !r_q & t_w[1];
    fe2  = !r_q & t_w[2];
    ir0  =  r_q & t_w[0];
    ir1  =  r_q & t_w[1];
    ir2  =  r_q & t_w[2];
    ind3 = !d_w[OP_OTHER] & ind_q & t_w[3];
    rd4  = (d_w[OP_AND] | d_w[OP_ADD] | d_w[OP_LOAD] | d_w[OP_INCSKIP]) & t_w[4];
    and5 = d_w[OP_AND]     & t_w[5];
    add5 = d_w[OP_ADD]     & t_w[5];
    lda5 = d_w[OP_LOAD]    & t_w[5];
    sta4 = d_w[OP_STORE]   & t_w[4];
    bun4 = d_w[OP_JUMP]    & t_w[4];
    bsa4 = d_w[OP_CALL]    & t_w[4];
    bsa5 = d_w[OP_CALL]    & t_w[5];
    isz5 = d_w[OP_INCSKIP] & t_w[5];
    isz6 = d_w[OP_INCSKIP] & t_w[6];
    oth4 = d_w[OP_OTHER]   & t_w[4];
    done_w = ir2 | and5 | add5 | lda5 | sta4 | bun4 | bsa5 | isz6 | oth4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ar_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
      ac_q  <= '0;
      ind_q <= 1'b0;
    end else begin
      if (fe0)       ar_q <= pc_q;
      else if (fe2)  ar_q <= ir_q[ADDR_W-1:0];
      else if (ind3) ar_q <= mem_rdata_i[ADDR_W-1:0];
      else if (ir0)  ar_q <= '0;
      else if (bsa4) ar_q <= ar_q + ADDR_W'(1);

      if (fe1 | ir2)                      pc_q <= pc_q + ADDR_W'(1);
      else if (ir1)                       pc_q <= '0;
      else if (bun4 | bsa5)               pc_q <= ar_q;
      else if (isz6 && dr_q == '0)        pc_q <= pc_q + ADDR_W'(1);

      if (fe1) ir_q  <= mem_rdata_i;
      if (fe2) ind_q <= ir_q[WORD_W-1];

      if (rd4)       dr_q <= mem_rdata_i;
      else if (isz5) dr_q <= dr_q + WORD_W'(1);

      if (and5)      ac_q <= ac_q & dr_q;
      else if (add5) ac_q <= ac_q + dr_q;
      else if (lda5) ac_q <= dr_q;
    end
  end

  always_comb begin
    mem_we_o = ir1 | sta4 | bsa4 | isz6;
    if (ir1 | bsa4)  mem_wdata_o = {{(WORD_W-ADDR_W){1'b0}}, pc_q};
    else if (sta4)   mem_wdata_o = ac_q;
    else             mem_wdata_o = dr_q;
  end

  assign mem_addr_o = ar_q;
  assign pc_o       = pc_q;
  assign ar_o       = ar_q;
  assign ir_o       = ir_q;
  assign dr_o       = dr_q;
  assign ac_o       = ac_q;
  assign ind_o      = ind_q;
  assign irq_cyc_o  = r_q;
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = ADDR_W + 4,
  parameter int SW = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ien_i,
  input logic              fgi_i,
  input logic              fgo_i,
  input logic [WORD_W-1:0] mem_rdata_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] ar_o,
  input logic [WORD_W-1:0] ir_o,
  input logic              ind_o,
  input logic              irq_cyc_o,
  input logic [SW-1:0]     step_o
);
  p_fetch_ar_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_cyc_o && step_o == SW'(0)) |=> ar_o == $past(pc_o));

  p_fetch_ir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_cyc_o && step_o == SW'(1)) |=>
      (ir_o == $past(mem_rdata_i) && pc_o == $past(pc_o) + ADDR_W'(1)));

  p_indirect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == SW'(3) && ind_o && ir_o[WORD_W-2 -: 3] != 3'b111) |=>
      ar_o == $past(mem_rdata_i[ADDR_W-1:0]));

  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_cyc_o && step_o <= SW'(2)) |=> !irq_cyc_o);

  p_irq_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o > SW'(2) && ien_i && (fgi_i || fgo_i)) |=> irq_cyc_o);

  p_irq_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_cyc_o && step_o == SW'(2)) |=>
      (!irq_cyc_o && step_o == SW'(0) && pc_o == ADDR_W'(1)));

  p_we_slot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((irq_cyc_o && step_o == SW'(1)) || step_o == SW'(4) || step_o == SW'(6)));

  p_t6_end_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == SW'(6)) |=> step_o == SW'(0));
endmodule

bind acc_seq_core acc_seq_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SW(SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ien_i(ien_i), .fgi_i(fgi_i), .fgo_i(fgo_i),
  .mem_rdata_i(mem_rdata_i), .mem_we_o(mem_we_o), .pc_o(pc_o), .ar_o(ar_o),
  .ir_o(ir_o), .ind_o(ind_o), .irq_cyc_o(irq_cyc_o), .step_o(step_o)
);

// File: tb/acc_seq_core_test.sv
module acc_seq_core_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ien = 1'b0, fgi = 1'b0, fgo = 1'b0;
  logic [15:0] rdata, wdata, ir, dr, ac;
  logic [11:0] addr, pc, ar;
  logic        we, ind, rcyc;
  logic [2:0]  step;
  logic [15:0] mem [0:4095];
  int          total = 0, bad = 0, wr_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  acc_seq_core uut (
    .clk_i(clk), .rst_ni(rst_n), .ien_i(ien), .fgi_i(fgi), .fgo_i(fgo),
    .mem_rdata_i(rdata), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we),
    .pc_o(pc), .ar_o(ar), .ir_o(ir), .dr_o(dr), .ac_o(ac), .ind_o(ind),
    .irq_cyc_o(rcyc), .step_o(step)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (we) begin mem[addr] <= wdata; wr_cnt <= wr_cnt + 1; end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; ien = 0; fgi = 0; fgo = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_mem;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  // one memory-reference instruction after a LOAD that sets AC
  task automatic run_op(input int op, input int ia, input logic [15:0] opv, input logic [15:0] acv);
    logic [11:0] eff, exp_ar, exp_pc;
    logic [15:0] exp_ac, inc;
    int n, exp_wr, wr0;
    string tag;
    clear_mem();
    eff = ia ? 12'h200 : 12'h100;
    mem[0] = 16'h2050;
    mem[12'h050] = acv;
    mem[1] = {ia[0], op[2:0], 12'h100};
    mem[12'h100] = ia ? 16'h0200 : opv;
    if (ia) mem[12'h200] = opv;
    do_reset();
    repeat (6) tick();
    chk("R4", "load ac", ac, acv);
    chk("R12", "step after load", step, 3'd0);
    wr0 = wr_cnt;
    n = (op == 6) ? 7 : (op == 3 || op == 4 || op == 7) ? 5 : 6;
    repeat (n - 1) tick();
    chk("R12", "last slot", step, n - 1);
    tick();
    chk("R12", "step at end", step, 3'd0);
    exp_ac = acv; exp_pc = 12'h002; exp_ar = eff; exp_wr = 0;
    inc = opv + 16'h0001;
    tag = (op <= 2) ? "R4" : (op <= 4) ? "R5" : (op == 5) ? "R6" : (op == 6) ? "R7" : "R8";
    case (op)
      0: exp_ac = acv & opv;
      1: exp_ac = acv + opv;
      2: exp_ac = opv;
      3: exp_wr = 1;
      4: exp_pc = eff;
      5: begin exp_wr = 1; exp_pc = eff + 12'h001; exp_ar = eff + 12'h001; end
      6: begin exp_wr = 1; if (inc == 16'h0000) exp_pc = 12'h003; end
      default: exp_ar = 12'h100;
    endcase
    chk(tag, "ac", ac, exp_ac);
    chk(tag, "pc", pc, exp_pc);
    chk("R3", "ar", ar, exp_ar);
    chk("R11", "write count", wr_cnt - wr0, exp_wr);
    if (op == 3) chk("R5", "stored word", mem[eff], acv);
    if (op == 5) chk("R6", "return word", mem[eff], 16'h0002);
    if (op == 6) chk("R7", "incremented word", mem[eff], inc);
    if (op == 7) begin
      chk("R8", "ptr untouched", mem[12'h100], ia ? 16'h0200 : opv);
      chk("R8", "ac untouched", ac, acv);
    end
  endtask

  // jump to 2CF, then the increment-and-skip example; optionally raise a request in T6
  task automatic worked(input bit irq_at_t6);
    clear_mem();
    mem[0] = 16'h42CF;
    mem[12'h2CF] = 16'hEB89;
    mem[12'h2D0] = 16'h8B91;
    mem[12'hB89] = 16'h0CDF;
    mem[12'hCDF] = 16'hFFFF;
    mem[12'h2D1] = 16'h5B90;
    do_reset();
    repeat (5) tick();
    chk("R5", "jump pc", pc, 12'h2CF);
    tick(); chk("R2", "T0 ar", ar, 12'h2CF);
    tick(); chk("R2", "T1 pc", pc, 12'h2D0); chk("R2", "T1 ir", ir, 16'hEB89);
    tick(); chk("R2", "T2 ar", ar, 12'hB89); chk("R2", "T2 ind", ind, 1'b1);
    tick(); chk("R3", "T3 ar", ar, 12'hCDF);
    tick(); chk("R7", "T4 dr", dr, 16'hFFFF);
    tick(); chk("R7", "T5 dr", dr, 16'h0000);
    chk("R7", "T6 step", step, 3'd6);
    if (irq_at_t6) begin ien = 1; fgo = 1; end
    tick();
    chk("R7", "T6 pc", pc, 12'h2D1);
    chk("R7", "T6 mem", mem[12'hCDF], 16'h0000);
    chk("R7", "ac kept", ac, 16'h0000);
    if (!irq_at_t6) begin
      chk("R12", "no irq", rcyc, 1'b0);
      tick(); tick();
      chk("R2", "next fetch", ir, 16'h5B90);
    end else begin
      chk("R12", "irq pending at T0", rcyc, 1'b1);
      chk("R12", "step T0", step, 3'd0);
      ien = 0; fgo = 0;
      tick(); chk("R10", "irq T0 ar", ar, 12'h000);
      tick(); chk("R10", "irq T1 save", mem[0], 16'h02D1); chk("R10", "irq T1 pc", pc, 12'h000);
      tick(); chk("R10", "irq T2 pc", pc, 12'h001); chk("R10", "irq cleared", rcyc, 1'b0);
      chk("R10", "irq step", step, 3'd0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] opvs [4];
    opvs[0] = 16'hFFFF; opvs[1] = 16'h1234; opvs[2] = 16'h0000; opvs[3] = 16'h8001;
    clear_mem();
    do_reset();
    chk("R1", "step", step, 3'd0);
    chk("R1", "pc", pc, 12'h000);
    chk("R1", "ar", ar, 12'h000);
    chk("R1", "ir/dr/ac", {ir ^ dr ^ ac}, 16'h0000);
    chk("R1", "flags", {ind, rcyc}, 2'b00);

    for (int op = 0; op < 8; op++)
      for (int ia = 0; ia < 2; ia++)
        for (int v = 0; v < 4; v++)
          run_op(op, ia, opvs[v], (v[0]) ? 16'h0F0F : 16'hFFFF);

    worked(1'b0);
    worked(1'b1);

    // request window: ignored in T0..T2, gated by enable
    clear_mem();
    mem[0] = 16'h4010;
    mem[12'h010] = 16'h4020;
    do_reset();
    ien = 1; fgi = 1;
    tick(); chk("R9", "no set T0", rcyc, 1'b0);
    tick(); chk("R9", "no set T1", rcyc, 1'b0);
    tick(); chk("R9", "no set T2", rcyc, 1'b0);
    fgi = 0;
    tick(); chk("R9", "no flag", rcyc, 1'b0);
    ien = 0; fgi = 1;
    tick(); chk("R9", "disabled", rcyc, 1'b0); chk("R5", "jump 010", pc, 12'h010);
    fgi = 0;
    repeat (3) tick();
    ien = 1; fgo = 1;
    tick(); chk("R9", "set in T3", rcyc, 1'b1);
    ien = 0; fgo = 0;
    tick(); chk("R12", "pc 020", pc, 12'h020); chk("R12", "still pending", rcyc, 1'b1);
    tick(); chk("R10", "ar cleared", ar, 12'h000);
    tick(); chk("R10", "saved pc", mem[0], 16'h0020); chk("R11", "irq write", we, 1'b0);
    tick(); chk("R10", "resume pc", pc, 12'h001); chk("R10", "flag clear", rcyc, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule